// File: doc/BRIEF.md
# Multi-Tap Line-Scan Video Timing Generator

This block produces the frame and line qualifiers and a multi-pixel data bus for a parallel video source whose outputs are clocked by a single pixel clock (nominally 50 MHz). All outputs are registered on that clock or decoded directly from registered state. A downstream transmitter then captures them on the rising edge. A frame is requested with a one-cycle start pulse. Along with that pulse the host supplies the number of pixels carried per clock (two, four or eight), the pixel depth (8 or 10 bits), the number of lines in the frame and the number of blanking clocks between lines.

Each line carries the same number of pixels in every mode. The line therefore lasts 1176 clocks in the two-pixel mode, 588 in the four-pixel mode and 294 in the eight-pixel mode. The pixel values come from a built-in test pattern, so the framing can be checked end to end. Requests that cannot be honoured are refused and flagged, and no frame starts. Such requests are a line count outside 2 to 1726, 10-bit depth with eight pixels per clock, or an unknown mode code.

Top module: `vid_line_timer`

## Requirements
- R1: `mode_i` selects the pixels per clock: code 0 gives 2, code 1 gives 4, code 2 gives 8, and code 3 is invalid. Slot k of `pix_o` occupies bits [10k+9:10k]. Slots at or above the active count read zero.
- R2: A line holds `line_o` high for 1176, 588 or 294 consecutive clocks in the 2, 4 and 8 pixel modes respectively.
- R3: 10-bit depth is accepted only in the 2 and 4 pixel modes. With 8-bit depth the two top bits of every slot are zero.
- R4: An accepted frame contains exactly the requested number of `line_o` pulses. Any count from 2 to 1726 inclusive is accepted.
- R5: A start with a count outside 2..1726, with 10-bit depth in the 8 pixel mode, or with mode code 3 starts no frame. From the next clock it sets `err_o` high, and `err_o` stays high until a start is accepted.
- R6: `frame_o` rises on the clock after an accepted start, exactly one clock before the first `line_o`. It falls exactly one clock after the last `line_o` clock. `line_o` is never high without `frame_o`.
- R7: Between two lines of a frame, `line_o` stays low for `gap_i` clocks, or 1 clock when `gap_i` is 0.
- R8: `pix_o` is all zero whenever `line_o` is low.
- R9: During line n (counting from 0), clock c of the line (counting from 0), slot k carries (n + c*P + k) modulo 2^D. Here P is the number of pixels per clock and D is the depth.
- R10: Mode, depth, line count and gap are sampled only when a start is accepted. A start pulse while a frame runs is ignored, and input changes during a frame affect only the next one.
- R11: After reset, `frame_o`, `line_o`, `err_o` and `pix_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request pulse |
| mode_i | input | 2 | Pixels-per-clock code |
| wide_i | input | 1 | 1 selects 10-bit pixels |
| lines_i | input | 11 | Lines per frame |
| gap_i | input | 8 | Blanking clocks between lines |
| frame_o | output | 1 | Frame qualifier |
| line_o | output | 1 | Line qualifier |
| err_o | output | 1 | Last request refused |
| pix_o | output | 80 | Eight 10-bit pixel slots |

## Verification
The bench aims at the edges of the legal request space: line counts of 1, 2, 1726 and 1727, 10-bit depth paired with eight pixels per clock, and mode code 3. A design with a wrong bound would either start a frame it should refuse or leave `err_o` low. A zero gap checks the clamp to one clock; without it, adjacent lines would merge into one long pulse. Mid-frame changes of every setting, together with a second start pulse, check that the captured configuration holds: a design that reads live inputs would change line length or pattern partway through. Per-cycle comparison of the pattern across all three modes catches slot ordering errors, masking errors in 8-bit depth, and any data leaking into the blanking intervals.

// File: rtl/vlt_pkg.sv
package vlt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LINE,
    ST_GAP,
    ST_TRAIL
  } vlt_state_e;

  // pixels carried per clock for a mode code, 0 for an invalid code
  function automatic int taps_of(input logic [1:0] mode);
    case (mode)
      2'd0:    return 2;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 0;
    endcase
  endfunction

  // clocks of line-valid for one full line
  function automatic int line_clocks(input logic [1:0] mode, input int line_pix);
    int t;
    t = taps_of(mode);
    return (t == 0) ? 1 : line_pix / t;
  endfunction

  function automatic logic request_ok(input logic [1:0] mode, input logic wide,
                                      input int lines, input int min_l, input int max_l);
    return (mode != 2'd3) && !(mode == 2'd2 && wide) &&
           (lines >= min_l) && (lines <= max_l);
  endfunction

  // test pattern value for one slot
  function automatic int pattern_val(input int line, input int col,
                                     input logic [1:0] mode, input logic wide, input int slot);
    int mask;
    mask = wide ? 1023 : 255;
    return (line + col * taps_of(mode) + slot) & mask;
  endfunction

endpackage

// File: rtl/vlt_ctrl.sv
module vlt_ctrl
  import vlt_pkg::*;
#(
  parameter int LINE_PIX  = 2352,
  parameter int MIN_LINES = 2,
  parameter int MAX_LINES = 1726,
  parameter int LINES_W   = 11,
  parameter int COL_W     = 11,
  parameter int GAP_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic               wide_i,
  input  logic [LINES_W-1:0] lines_i,
  input  logic [GAP_W-1:0]   gap_i,
  output logic               frame_o,
  output logic               line_o,
  output logic               err_o,
  output logic [1:0]         cap_mode_o,
  output logic               cap_wide_o,
  output logic [LINES_W-1:0] line_idx_o,
  output logic [COL_W-1:0]   col_idx_o,
  output logic [COL_W-1:0]   line_len_o
);

  vlt_state_e         state_q;
  logic [LINES_W-1:0] cap_lines_q;
  logic [GAP_W-1:0]   cap_gap_q;
  logic [GAP_W-1:0]   gcnt_q;

  logic req_ok_w, accept_w, reject_w, line_end_w, last_line_w, gap_end_w;

  assign req_ok_w    = request_ok(mode_i, wide_i, int'(lines_i), MIN_LINES, MAX_LINES);
  assign accept_w    = start_i && (state_q == ST_IDLE) && req_ok_w;
  assign reject_w    = start_i && (state_q == ST_IDLE) && !req_ok_w;
  assign line_len_o  = COL_W'(line_clocks(cap_mode_o, LINE_PIX));
  assign line_end_w  = (state_q == ST_LINE) && (col_idx_o == line_len_o - 1'b1);
  assign last_line_w = (line_idx_o == cap_lines_q - 1'b1);
  assign gap_end_w   = (state_q == ST_GAP) && (gcnt_q >= cap_gap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cap_mode_o  <= 2'd0;
      cap_wide_o  <= 1'b0;
      cap_lines_q <= '0;
      cap_gap_q   <= GAP_W'(1);
      gcnt_q      <= '0;
      line_idx_o  <= '0;
      col_idx_o   <= '0;
      err_o       <= 1'b0;
    end else begin
      if (reject_w) err_o <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (accept_w) begin
          err_o       <= 1'b0;
          cap_mode_o  <= mode_i;
          cap_wide_o  <= wide_i;
          cap_lines_q <= lines_i;
          cap_gap_q   <= (gap_i == '0) ? GAP_W'(1) : gap_i;
          line_idx_o  <= '0;
          col_idx_o   <= '0;
          state_q     <= ST_LEAD;
        end
        ST_LEAD: state_q <= ST_LINE;
        ST_LINE: begin
          if (line_end_w) begin
            col_idx_o <= '0;
            gcnt_q    <= GAP_W'(1);
            state_q   <= last_line_w ? ST_TRAIL : ST_GAP;
          end else begin
            col_idx_o <= col_idx_o + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_end_w) begin
            line_idx_o <= line_idx_o + 1'b1;
            state_q    <= ST_LINE;
          end else begin
            gcnt_q <= gcnt_q + 1'b1;
          end
        end
        ST_TRAIL: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign frame_o = (state_q != ST_IDLE);
  assign line_o  = (state_q == ST_LINE);

endmodule

// File: rtl/vlt_pattern.sv
module vlt_pattern
  import vlt_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int MAX_TAPS = 8,
  parameter int LINES_W  = 11,
  parameter int COL_W    = 11
) (
  input  logic                      active_i,
  input  logic [1:0]                mode_i,
  input  logic                      wide_i,
  input  logic [LINES_W-1:0]        line_i,
  input  logic [COL_W-1:0]          col_i,
  output logic [MAX_TAPS*PIX_W-1:0] pix_o
);

  for (genvar k = 0; k < MAX_TAPS; k++) begin : g_slot
    logic on_w;
    assign on_w = active_i && (k < taps_of(mode_i));
    assign pix_o[k*PIX_W +: PIX_W] =
      on_w ? PIX_W'(pattern_val(int'(line_i), int'(col_i), mode_i, wide_i, k)) : '0;
  end

endmodule

// File: rtl/vid_line_timer.sv
module vid_line_timer #(
  parameter int  PIX_W     = 10,
  parameter int  MAX_TAPS  = 8,
  parameter int  LINE_PIX  = 2352,
  parameter int  MIN_LINES = 2,
  parameter int  MAX_LINES = 1726,
  parameter int  GAP_W     = 8,
  localparam int LINES_W   = $clog2(MAX_LINES + 1),
  localparam int COL_W     = $clog2(LINE_PIX / 2 + 1),
  localparam int BUS_W     = MAX_TAPS * PIX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic               wide_i,
  input  logic [LINES_W-1:0] lines_i,
  input  logic [GAP_W-1:0]   gap_i,
  output logic               frame_o,
  output logic               line_o,
  output logic               err_o,
  output logic [BUS_W-1:0]   pix_o
);

  // named internal events, also observed by the bound checker
  logic [1:0]         cap_mode_w;
  logic               cap_wide_w;
  logic [LINES_W-1:0] line_idx_w;
  logic [COL_W-1:0]   col_idx_w;
  logic [COL_W-1:0]   line_len_w;

  vlt_ctrl #(
    .LINE_PIX (LINE_PIX),
    .MIN_LINES(MIN_LINES),
    .MAX_LINES(MAX_LINES),
    .LINES_W  (LINES_W),
    .COL_W    (COL_W),
    .GAP_W    (GAP_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .wide_i    (wide_i),
    .lines_i   (lines_i),
    .gap_i     (gap_i),
    .frame_o   (frame_o),
    .line_o    (line_o),
    .err_o     (err_o),
    .cap_mode_o(cap_mode_w),
    .cap_wide_o(cap_wide_w),
    .line_idx_o(line_idx_w),
    .col_idx_o (col_idx_w),
    .line_len_o(line_len_w)
  );

  vlt_pattern #(
    .PIX_W   (PIX_W),
    .MAX_TAPS(MAX_TAPS),
    .LINES_W (LINES_W),
    .COL_W   (COL_W)
  ) u_pat (
    .active_i(line_o),
    .mode_i  (cap_mode_w),
    .wide_i  (cap_wide_w),
    .line_i  (line_idx_w),
    .col_i   (col_idx_w),
    .pix_o   (pix_o)
  );

endmodule

// File: rtl/vlt_checker.sv
module vlt_checker #(
  parameter int PIX_W     = 10,
  parameter int MAX_TAPS  = 8,
  parameter int COL_W     = 11,
  parameter int MIN_LINES = 2,
  parameter int MAX_LINES = 1726
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      frame_o,
  input logic                      line_o,
  input logic                      err_o,
  input logic [MAX_TAPS*PIX_W-1:0] pix_o,
  input logic                      cap_wide_w,
  input logic [COL_W-1:0]          line_len_w
);

  logic [COL_W:0] run_q;
  logic [15:0]    nlines_q;
  logic           line_d;
  logic [MAX_TAPS-1:0] hi_bits;

  for (genvar k = 0; k < MAX_TAPS; k++) begin : g_hi
    assign hi_bits[k] = |pix_o[k*PIX_W+8 +: PIX_W-8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      nlines_q <= '0;
      line_d   <= 1'b0;
    end else begin
      line_d <= line_o;
      run_q  <= line_o ? run_q + 1'b1 : '0;
      if (!frame_o)              nlines_q <= '0;
      else if (line_o && !line_d) nlines_q <= nlines_q + 1'b1;
    end
  end

  assert_line_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_o) |-> (run_q == {1'b0, line_len_w}));

  assert_narrow_pixels_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_o && !cap_wide_w) |-> (hi_bits == '0));

  assert_line_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_o) |-> (nlines_q >= 16'(MIN_LINES) && nlines_q <= 16'(MAX_LINES)));

  assert_err_no_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !frame_o);

  assert_line_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_o |-> frame_o);

  assert_frame_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> !line_o);

  assert_frame_trail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_o) |-> !$past(line_o));

  assert_pix_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_o |-> (pix_o == '0));

endmodule

bind vid_line_timer vlt_checker #(
  .PIX_W    (PIX_W),
  .MAX_TAPS (MAX_TAPS),
  .COL_W    (COL_W),
  .MIN_LINES(MIN_LINES),
  .MAX_LINES(MAX_LINES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_o   (frame_o),
  .line_o    (line_o),
  .err_o     (err_o),
  .pix_o     (pix_o),
  .cap_wide_w(cap_wide_w),
  .line_len_w(line_len_w)
);

// File: tb/vid_line_timer_bench.sv
`timescale 1ns/1ps
module vid_line_timer_bench;

  typedef struct {
    logic        fv;
    logic        lv;
    logic [79:0] px;
  } cyc_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        wide_i = 1'b0;
  logic [10:0] lines_i = 11'd2;
  logic [7:0]  gap_i = 8'd1;
  logic        frame_o, line_o, err_o;
  logic [79:0] pix_o;

  always #10 clk = ~clk;

  vid_line_timer u_vid_line_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .wide_i(wide_i), .lines_i(lines_i), .gap_i(gap_i),
    .frame_o(frame_o), .line_o(line_o), .err_o(err_o), .pix_o(pix_o)
  );

  cyc_t q[$];
  int   checks = 0, fails = 0;
  logic exp_err = 1'b0, busy_now = 1'b0;
  logic prev_fv = 1'b0, prev_lv = 1'b0;
  int   flen = 0, rises = 0, exp_lines = 0, exp_flen = 0;

  task automatic check(input logic ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // build the expected cycle stream of one frame from the requirements
  task automatic push_frame(input logic [1:0] m, input logic w, input int n, input int g);
    int p, len, gg;
    cyc_t c;
    p   = (m == 0) ? 2 : (m == 1) ? 4 : 8;
    len = 2352 / p;
    gg  = (g == 0) ? 1 : g;
    c.fv = 1; c.lv = 0; c.px = '0;
    q.push_back(c);
    for (int ln = 0; ln < n; ln++) begin
      for (int col = 0; col < len; col++) begin
        c.fv = 1; c.lv = 1; c.px = '0;
        for (int s = 0; s < p; s++)
          c.px[s*10 +: 10] = 10'((ln + col * p + s) % (w ? 1024 : 256));
        q.push_back(c);
      end
      if (ln < n - 1)
        for (int b = 0; b < gg; b++) begin
          c.fv = 1; c.lv = 0; c.px = '0;
          q.push_back(c);
        end
    end
    c.fv = 1; c.lv = 0; c.px = '0;
    q.push_back(c);
    exp_lines = n;
    exp_flen  = 2 + n * len + (n - 1) * gg;
  endtask

  task automatic tick();
    cyc_t e;
    @(negedge clk);
    busy_now = (q.size() > 0);
    if (busy_now) e = q.pop_front();
    else begin e.fv = 0; e.lv = 0; e.px = '0; end
    check(frame_o === e.fv, "R6", "frame_o", 80'(frame_o), 80'(e.fv));
    check(line_o === e.lv, "R2 R7", "line_o", 80'(line_o), 80'(e.lv));
    check(pix_o === e.px, "R1 R3 R8 R9", "pix_o", pix_o, e.px);
    check(err_o === exp_err, "R5", "err_o", 80'(err_o), 80'(exp_err));
    if (frame_o) begin
      flen++;
      if (line_o && !prev_lv) rises++;
    end
    if (prev_fv && !frame_o) begin
      check(rises == exp_lines, "R4", "line pulses", 80'(rises), 80'(exp_lines));
      check(flen == exp_flen, "R10", "frame length", 80'(flen), 80'(exp_flen));
      flen = 0; rises = 0;
    end
    prev_fv = frame_o;
    prev_lv = line_o;
  endtask

  task automatic try_start(input logic [1:0] m, input logic w, input int n, input int g);
    mode_i = m; wide_i = w; lines_i = 11'(n); gap_i = 8'(g); start_i = 1'b1;
    if (!busy_now) begin
      if (m != 3 && !(m == 2 && w) && n >= 2 && n <= 1726) begin
        push_frame(m, w, n, g);
        exp_err = 1'b0;
      end else exp_err = 1'b1;
    end
    tick();
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) tick();
    repeat (3) tick();
  endtask

  initial begin
    // R11: reset state
    tick();
    check(!frame_o && !line_o && !err_o && pix_o == '0, "R11", "reset outputs",
          {frame_o, line_o, err_o, pix_o[76:0]}, '0);
    rst_n = 1'b1;
    repeat (2) tick();

    // R2 R9: eight slots, 8-bit, gap of 3
    try_start(2'd2, 1'b0, 2, 3);
    drain();
    // R1 R3: four slots, 10-bit, three lines, gap of 1
    try_start(2'd1, 1'b1, 3, 1);
    drain();
    // R7: two slots, 10-bit, gap 0 clamps to 1
    try_start(2'd0, 1'b1, 2, 0);
    drain();

    // R5: refused requests
    try_start(2'd2, 1'b0, 1, 2);
    repeat (3) tick();
    try_start(2'd2, 1'b1, 2, 2);
    repeat (3) tick();
    try_start(2'd3, 1'b0, 4, 2);
    repeat (3) tick();
    try_start(2'd1, 1'b0, 1727, 2);
    repeat (3) tick();
    check(err_o === 1'b1 && frame_o === 1'b0, "R5", "refusal holds", 80'({err_o, frame_o}), 80'(2'b10));

    // R4 R5: lower bound accepted, clears error
    try_start(2'd2, 1'b0, 2, 1);
    drain();

    // R10: mid-frame changes and a second start are ignored
    try_start(2'd1, 1'b0, 2, 2);
    repeat (100) tick();
    try_start(2'd0, 1'b1, 5, 7);
    repeat (50) tick();
    mode_i = 2'd3; lines_i = 11'd0; gap_i = 8'd0;
    drain();
    // R10: the changed settings take effect on the next frame
    try_start(2'd0, 1'b0, 2, 5);
    drain();

    // R4: upper bound accepted, then reset mid-frame
    try_start(2'd2, 1'b0, 1726, 1);
    repeat (700) tick();
    rst_n = 1'b0;
    q.delete(); exp_err = 1'b0; busy_now = 1'b0;
    prev_fv = 1'b0; prev_lv = 1'b0; flen = 0; rises = 0;
    tick();
    check(!frame_o && !line_o && pix_o == '0, "R11", "reset mid-frame",
          {frame_o, line_o, pix_o[77:0]}, '0);
    rst_n = 1'b1;
    repeat (3) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule